// File: doc/BRIEF.md
# Streaming Random Bit Health Monitor

This block watches a serial stream of random bits and applies three statistical health checks to one window of 20,000 accepted bits. The checks are a count of ones, a test on how often each 4-bit value occurs, and a check for runs of equal bits that are too long. A bit counts only when its valid qualifier is high. When the window is complete, the block reports a verdict for each test and a combined verdict. It then holds these results until software or a sequencer asks for a new window.

The block computes the 4-bit value test with integer arithmetic only. After the window it makes one multiply-accumulate pass over the sixteen value counters, one counter per cycle. It compares the resulting sum of squares with integer limits chosen to match the fractional acceptance band, so no divider is needed. The one-count and run-length tests are checked as the bits arrive.

A start strobe clears the block and opens a window. After reset the block is idle and ignores the stream until the first start.

Top module: `rng_health_monitor`

## Requirements
- R1: After a start strobe, exactly 20,000 bits taken on cycles with `bit_vld` high form the window. Bits on cycles with `bit_vld` low, bits before the first start, and bits after the window closes have no effect on any result.
- R2: `pass_mono` is 1 only when the number of ones X in the window satisfies 9654 < X < 10346. Both limits are excluded.
- R3: The window is cut into 5,000 consecutive 4-bit values, and the earliest bit of each group is its most significant bit. f(v) is the number of times value v occurs. `pass_poker` is 1 exactly when 1562822 <= sum of f(v)^2 <= 1580437.
- R4: `pass_run` is 0 when any run of equal bits (zeros or ones) in the window is longer than 33. A run of exactly 33 still passes.
- R5: `done` rises 16 clock cycles after the rising edge that accepted the last bit of the window. `pass_all` equals the AND of the three test flags.
- R6: While `done` is 0, all pass outputs are 0. Once `done` is 1, `done` and every flag stay constant until the next start strobe, even if more bits arrive.
- R7: A start strobe clears every counter and flag in one cycle and opens a new window, even in the middle of a window. The bit offered on the start cycle is not taken.
- R8: After synchronous reset, `done` and all pass outputs are 0, and the block stays idle until a start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Clears the block and opens a new window |
| bit_in | input | 1 | Random bit under test |
| bit_vld | input | 1 | Qualifies `bit_in` on this cycle |
| done | output | 1 | Window finished, results valid |
| pass_all | output | 1 | All three tests passed |
| pass_mono | output | 1 | Ones-count test passed |
| pass_poker | output | 1 | 4-bit value test passed |
| pass_run | output | 1 | Long-run test passed |

## Verification
The embedded assertions assume two things about the inputs. Reset is applied before the first start, and `start` is a pulse, never held across the closing of a window. The bench always drives `start` high for exactly one cycle, with `bit_vld` low on that cycle. It never raises `start` while the block is scanning its counters, except where a mid-window restart is the intended stimulus. The windows the bench uses are uniform, alternating, near-balanced, run-boundary and ones-count-boundary patterns. For each one the bench computes the expected statistics from the bit array it drives.

// File: rtl/rng_health_monitor.sv
module rng_health_monitor #(
  parameter int NBITS   = 20000,
  parameter int ONES_LO = 9654,
  parameter int ONES_HI = 10346,
  parameter int SQ_LO   = 1562822,
  parameter int SQ_HI   = 1580437,
  parameter int RUN_MAX = 33
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic bit_in,
  input  logic bit_vld,
  output logic done,
  output logic pass_all,
  output logic pass_mono,
  output logic pass_poker,
  output logic pass_run
);
  localparam int CW = $clog2(NBITS + 1);
  localparam int FW = $clog2(NBITS / 4 + 1);
  localparam int SW = 2 * FW + 4;
  localparam int RW = $clog2(RUN_MAX + 2);

  logic          busy, scan, last, run_fail;
  logic [3:0]    idx;
  logic [1:0]    ph;
  logic [2:0]    sh;
  logic [CW-1:0] cnt, ones;
  logic [SW-1:0] acc, sq;
  logic [RW-1:0] run_len, run_nxt;
  logic [FW-1:0] freq [16];

  wire take = busy & bit_vld & ~start;

  assign sq = SW'(freq[idx]) * SW'(freq[idx]);
  assign run_nxt = (cnt != '0 && bit_in == last)
                 ? ((run_len == RW'(RUN_MAX + 1)) ? run_len : run_len + RW'(1))
                 : RW'(1);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      busy     <= start;
      scan     <= 1'b0;
      done     <= 1'b0;
      cnt      <= '0;
      ones     <= '0;
      sh       <= '0;
      ph       <= '0;
      idx      <= '0;
      acc      <= '0;
      run_len  <= '0;
      last     <= 1'b0;
      run_fail <= 1'b0;
      for (int i = 0; i < 16; i++) freq[i] <= '0;
    end else begin
      if (take) begin
        cnt     <= cnt + CW'(1);
        ones    <= ones + CW'(bit_in);
        sh      <= {sh[1:0], bit_in};
        ph      <= ph + 2'd1;
        last    <= bit_in;
        run_len <= run_nxt;
        if (ph == 2'd3) freq[{sh, bit_in}] <= freq[{sh, bit_in}] + FW'(1);
        if (run_nxt > RW'(RUN_MAX)) run_fail <= 1'b1;
        if (cnt == CW'(NBITS - 1)) begin
          busy <= 1'b0;
          scan <= 1'b1;
          idx  <= '0;
        end
      end
      if (scan) begin
        acc <= acc + sq;
        idx <= idx + 4'd1;
        if (idx == 4'd15) begin
          scan <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign pass_mono  = done & (ones > CW'(ONES_LO)) & (ones < CW'(ONES_HI));
  assign pass_poker = done & (acc >= SW'(SQ_LO)) & (acc <= SW'(SQ_HI));
  assign pass_run   = done & ~run_fail;
  assign pass_all   = pass_mono & pass_poker & pass_run;

  assert_window_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(NBITS));
  assert_ones_within_count_R2: assert property (@(posedge clk) disable iff (rst)
    ones <= cnt);
  assert_run_latched_R4: assert property (@(posedge clk) disable iff (rst)
    run_fail && !start |=> run_fail);
  assert_run_saturates_R4: assert property (@(posedge clk) disable iff (rst)
    run_len <= RW'(RUN_MAX + 1));
  assert_results_hold_R6: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done && $stable(pass_all) && $stable(pass_mono)
                       && $stable(pass_poker) && $stable(pass_run));
  assert_start_clears_R7: assert property (@(posedge clk) disable iff (rst)
    start |=> !done && !scan && cnt == '0);
  assert_phases_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy, scan, done}));
endmodule

// File: tb/rng_health_monitor_test.sv
module rng_health_monitor_test;
  localparam int N = 20000;
  logic clk = 0, rst = 1, start = 0, bit_in = 0, bit_vld = 0;
  logic done, pass_all, pass_mono, pass_poker, pass_run;
  int errors = 0, checks = 0;
  logic win [N];

  rng_health_monitor uut (.clk(clk), .rst(rst), .start(start), .bit_in(bit_in),
    .bit_vld(bit_vld), .done(done), .pass_all(pass_all), .pass_mono(pass_mono),
    .pass_poker(pass_poker), .pass_run(pass_run));

  always #5 clk = ~clk;

  initial begin
    repeat (195000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected finished)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1; bit_vld = 0;
    @(negedge clk); start = 0;
  endtask

  function automatic int nib_at(input int n);
    if (n < 4800) return n % 16;
    return (n % 2 == 0) ? 3 : 12;
  endfunction

  task automatic fill(input int kind);
    for (int j = 0; j < N; j++) begin
      case (kind)
        0: win[j] = 1'b0;
        1: win[j] = 1'(j % 2);
        default: win[j] = 1'((nib_at(j / 4) >> (3 - j % 4)) & 1);
      endcase
    end
  endtask

  task automatic make_run(input int p, input int len);
    win[p - 1] = 1'b0;
    for (int j = p; j < p + len; j++) win[j] = 1'b1;
    win[p + len] = 1'b0;
  endtask

  task automatic drop_ones(input int k);
    int left = k;
    for (int j = 3; j < N && left > 0; j += 4)
      if (win[j]) begin win[j] = 1'b0; left--; end
  endtask

  task automatic run_window(input string tag, input int gapmod, output int ones_o, output int run_o);
    int freq [16];
    int sumsq = 0, ones = 0, run = 0, maxrun = 0, e = 0;
    for (int v = 0; v < 16; v++) freq[v] = 0;
    for (int j = 0; j < N; j++) begin
      ones += int'(win[j]);
      run = (j > 0 && win[j] == win[j - 1]) ? run + 1 : 1;
      if (run > maxrun) maxrun = run;
      if (j % 4 == 3)
        freq[{win[j - 3], win[j - 2], win[j - 1], win[j]}]++;
    end
    for (int v = 0; v < 16; v++) sumsq += freq[v] * freq[v];
    pulse_start();
    for (int j = 0; j < N; j++) begin
      if (gapmod > 0 && j % gapmod == 0) begin
        bit_vld = 0; bit_in = 1; @(negedge clk);
      end
      bit_vld = 1; bit_in = win[j];
      @(negedge clk);
      if (j == N - 2) check({tag, " R6 flags low before done"}, int'({done, pass_all}), 0);
    end
    bit_vld = 0;
    while (!done && e < 40) begin @(negedge clk); e++; end
    check({tag, " R5 done latency"}, e, 16);
    check({tag, " R2 mono"}, int'(pass_mono), int'(ones > 9654 && ones < 10346));
    check({tag, " R3 poker"}, int'(pass_poker), int'(sumsq >= 1562822 && sumsq <= 1580437));
    check({tag, " R4 run"}, int'(pass_run), int'(maxrun <= 33));
    check({tag, " R5 all"}, int'(pass_all), int'(ones > 9654 && ones < 10346 &&
          sumsq >= 1562822 && sumsq <= 1580437 && maxrun <= 33));
    ones_o = ones; run_o = maxrun;
  endtask

  initial begin
    int o, r;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R8 reset state", int'({done, pass_all, pass_mono, pass_poker, pass_run}), 0);
    bit_vld = 1; bit_in = 1;
    repeat (100) @(negedge clk);
    bit_vld = 0;
    check("R8 idle ignores bits before start", int'(done), 0);

    fill(0);
    run_window("zeros", 0, o, r);
    check("R2 all zeros fail mono", int'(pass_mono), 0);
    check("R4 all zeros fail run", int'(pass_run), 0);

    pulse_start();
    bit_vld = 1; bit_in = 1;
    repeat (5000) @(negedge clk);
    bit_vld = 0;
    fill(1);
    run_window("alt after R7 restart", 0, o, r);
    check("R7 restart gives clean count (mono pass)", int'(pass_mono), 1);
    check("R3 single value fails poker", int'(pass_poker), 0);

    fill(2);
    run_window("balanced R1 gaps", 5, o, r);
    check("R1 balanced window passes all", int'(pass_all), 1);
    bit_vld = 1;
    for (int j = 0; j < 300; j++) begin bit_in = 1'(j % 3 == 0); @(negedge clk); end
    bit_vld = 0;
    check("R6 results held after extra bits", int'({done, pass_all, pass_mono, pass_poker, pass_run}), 5'b11111);

    fill(2); make_run(2001, 33);
    run_window("run33", 0, o, r);
    check("R4 run of 33 passes", int'(pass_run), 1);

    fill(2); make_run(2001, 34);
    run_window("run34", 0, o, r);
    check("R4 run of 34 fails", int'(pass_run), 0);

    fill(2); drop_ones(346);
    run_window("ones9654", 0, o, r);
    check("R2 ones count 9654", o, 9654);
    check("R2 X=9654 fails", int'(pass_mono), 0);

    fill(2); drop_ones(345);
    run_window("ones9655", 0, o, r);
    check("R2 X=9655 passes", int'(pass_mono), 1);

    @(negedge clk); start = 1; @(negedge clk); start = 0;
    check("R7 start clears results", int'({done, pass_all, pass_mono, pass_poker, pass_run}), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule